// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits on the controller side of a four-bank double-data-rate DRAM. A user port presents one request at a time: read or write, a bank, a row, a column and an auto-precharge choice. The sequencer turns each request into the command stream the memory expects. When the bank is closed it opens the row. When the bank holds a different row it closes that row first. It then issues the column access. The command and address outputs are registered and change once per rising clock. A No-Operation code is driven whenever nothing is due.

Each bank's open row is kept separately, so rows stay open across requests to other banks. A refresh scheduler raises a deadline every `T_REFI` clocks. That deadline takes priority over a waiting request. The sequencer closes every open bank with a precharge-all, issues Auto Refresh, and then lets the held request continue. A read-data-valid strobe follows each read. It is delayed by the configured CAS latency and lasts as many clocks as the burst needs. A companion flag marks the half-cycle latency setting.

The column field must fit below the auto-precharge address bit (`COL_W <= AP_BIT`).

Top module: `ddr_cmd_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the command pins show No-Operation ({cs_n,ras_n,cas_n,we_n} = 0111), and `req_ack`, `rd_valid` and `rd_half` are low.
- R2: At most one command is driven per clock, with the encodings Activate 0011, Read 0101, Write 0100, Precharge 0010 and Refresh 0001 on {cs_n,ras_n,cas_n,we_n}. Every cycle without a command shows 0111.
- R3: A request to a closed bank first issues Activate, with the bank on `cmd_ba` and the row on `cmd_addr`. Read or Write follows exactly `T_RCD` cycles later, with the column on the low `cmd_addr` bits.
- R4: A request whose row is already open in its bank issues Read or Write directly, with no Activate or Precharge.
- R5: A request to a bank holding a different row issues a single-bank Precharge (`cmd_addr[AP_BIT]` = 0). Activate follows `T_RP` cycles later, then Read or Write `T_RCD` cycles after that.
- R6: `cmd_addr[AP_BIT]` on Read or Write equals the request's auto-precharge flag. When the flag is set, the bank becomes closed once the burst completes. A following request to that bank then starts with Activate, exactly (latency + BL/2 + `T_RP`) cycles after the Read.
- R7: `cfg_burst` selects 2 (0), 4 (1) or 8 (2 or 3) locations. Each read drives `rd_valid` high for BL/2 consecutive cycles. A write drives no `rd_valid`.
- R8: `cfg_cas` selects CAS latency 2 (0), 2.5 (1) or 3 (2 or 3). `rd_valid` rises 2, 2 or 3 cycles after the Read cycle. `rd_half` is high together with `rd_valid` only for the 2.5 setting, which marks data arriving half a clock later.
- R9: A refresh falls due every `T_REFI` cycles. If any bank is open, a Precharge with `cmd_addr[AP_BIT]` = 1 comes first and Refresh follows `T_RP` cycles later. No command follows Refresh within `T_RFC` cycles.
- R10: A due refresh pre-empts a pending request. The held request's Activate comes exactly `T_RFC` cycles after the Refresh.
- R11: Opening or using a row in one bank leaves the open rows of the other banks intact.
- R12: `req_ack` pulses for one cycle, in the cycle a Read or Write appears on the pins. The request must stay asserted until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst | input | 2 | Burst length code (0: 2, 1: 4, 2/3: 8) |
| cfg_cas | input | 2 | CAS latency code (0: 2, 1: 2.5, 2/3: 3) |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the bank after this burst |
| req_bank | input | BA_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request starting column |
| req_ack | output | 1 | Request accepted (column command issued) |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BA_W | Command bank address |
| cmd_addr | output | ADDR_W | Command row/column address, AP_BIT flag |
| rd_valid | output | 1 | Read data expected this cycle |
| rd_half | output | 1 | Read data shifted by half a clock (latency 2.5) |

## Verification
On every cycle, the assertions check several ordering rules. A column command may only target a bank the table holds open. Refresh may only occur with every bank closed. A single-bank precharge must leave its bank closed. The cycle after an Activate must be idle when `T_RCD` exceeds one. The acknowledge must coincide with a column command. A read burst may not restart the data tracker before it has drained. A refresh deadline may not be missed twice. The exact spacings only come out of the bench's scenarios: the gaps between Precharge, Activate, Read and Refresh, and the auto-precharge reopen delay. The same holds for the held request after a refresh, the rise and length of `rd_valid` across all nine latency and burst combinations, and the survival of rows in other banks.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001
  } ddr_cmd_e;

  // data clocks per burst: locations / 2
  function automatic logic [3:0] burst_beats(input logic [1:0] bl_code);
    case (bl_code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

  // whole clocks of read latency (2.5 rounds down, half flagged apart)
  function automatic logic [1:0] cas_whole(input logic [1:0] cl_code);
    return (cl_code >= 2'd2) ? 2'd3 : 2'd2;
  endfunction

  function automatic logic cas_half(input logic [1:0] cl_code);
    return cl_code == 2'd1;
  endfunction

  // clocks the column access occupies before the next command
  function automatic logic [3:0] burst_hold(input logic is_write,
                                            input logic [1:0] bl_code,
                                            input logic [1:0] cl_code);
    return burst_beats(bl_code) + (is_write ? 4'd1 : {2'b00, cas_whole(cl_code)});
  endfunction

endpackage

// File: rtl/ddr_bank_table.sv
module ddr_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [BA_W-1:0]      set_bank,
  input  logic [ROW_W-1:0]     set_row,
  input  logic                 clr_en,
  input  logic [BA_W-1:0]      clr_bank,
  input  logic                 clr_all,
  input  logic [BA_W-1:0]      look_bank,
  input  logic [ROW_W-1:0]     look_row,
  output logic [NUM_BANKS-1:0] open_vec,
  output logic                 look_open,
  output logic                 look_hit
);

  logic [ROW_W-1:0] row_arr [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             open_b;
    logic [ROW_W-1:0] row_b;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_b <= 1'b0;
        row_b  <= '0;
      end else if (clr_all || (clr_en && clr_bank == BA_W'(b))) begin
        open_b <= 1'b0;
      end else if (set_en && set_bank == BA_W'(b)) begin
        open_b <= 1'b1;
        row_b  <= set_row;
      end
    end
    assign open_vec[b] = open_b;
    assign row_arr[b]  = row_b;
  end

  assign look_open = open_vec[look_bank];
  assign look_hit  = look_open && (row_arr[look_bank] == look_row);

  // R3: an activate may only target a bank that is closed
  assert_act_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !open_vec[set_bank]);

endmodule

// File: rtl/ddr_refresh_timer.sv
module ddr_refresh_timer #(
  parameter int T_REFI  = 1560,
  localparam int CNT_W  = $clog2(T_REFI)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_issued,
  output logic ref_due
);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_W'(T_REFI - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ref_due <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)            ref_due <= 1'b1;
      else if (ref_issued) ref_due <= 1'b0;
    end
  end

  // R9: a deadline must be served before the next one arrives
  assert_deadline_served_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (!ref_due || ref_issued));

endmodule

// File: rtl/ddr_read_track.sv
module ddr_read_track
  import ddr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] bl_code,
  input  logic [1:0] cl_code,
  output logic       rd_valid,
  output logic       rd_half
);

  logic [1:0] delay_q;
  logic [2:0] beats_q;
  logic       half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_q <= '0;
      beats_q <= '0;
      half_q  <= 1'b0;
    end else if (start) begin
      delay_q <= cas_whole(cl_code);
      beats_q <= 3'(burst_beats(bl_code));
      half_q  <= cas_half(cl_code);
    end else if (delay_q != 2'd0) begin
      delay_q <= delay_q - 1'b1;
    end else if (beats_q != 3'd0) begin
      beats_q <= beats_q - 1'b1;
    end
  end

  assign rd_valid = (delay_q == 2'd0) && (beats_q != 3'd0);
  assign rd_half  = rd_valid && half_q;

  // R7: a new read never starts before the previous burst reaches its last beat
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (delay_q == 2'd0) && (beats_q <= 3'd1));

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 14,
  parameter int T_REFI    = 1560,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_burst,
  input  logic [1:0]        cfg_cas,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_autopre,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ack,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BA_W-1:0]   cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              rd_valid,
  output logic              rd_half
);

  localparam int T_A    = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int T_B    = (T_A > T_RFC) ? T_A : T_RFC;
  localparam int T_MAX  = (T_B > 8) ? T_B : 8;
  localparam int WAIT_W = $clog2(T_MAX + 1);

  typedef enum logic {ST_IDLE, ST_BURST} seq_st_e;

  seq_st_e             st_q, st_d;
  logic [WAIT_W-1:0]   wait_q, wait_d;
  ddr_cmd_e            cmd_q, cmd_d;
  logic [BA_W-1:0]     ba_q, ba_d, ap_bank_q, clr_bank;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                ack_q;

  // named internal events
  logic [NUM_BANKS-1:0] open_vec;
  logic                 look_open, look_hit, ref_due;
  logic                 tbl_set, tbl_clr, tbl_clr_all, ref_issue, rw_take, burst_end;

  always_comb begin
    cmd_d       = CMD_NOP;
    ba_d        = '0;
    addr_d      = '0;
    st_d        = st_q;
    wait_d      = (wait_q != '0) ? wait_q - 1'b1 : '0;
    tbl_set     = 1'b0;
    tbl_clr     = 1'b0;
    tbl_clr_all = 1'b0;
    ref_issue   = 1'b0;
    rw_take     = 1'b0;
    burst_end   = 1'b0;
    clr_bank    = req_bank;
    if (wait_q == '0) begin
      if (st_q == ST_BURST) begin
        burst_end = 1'b1;
        tbl_clr   = 1'b1;
        clr_bank  = ap_bank_q;
        st_d      = ST_IDLE;
        wait_d    = WAIT_W'(T_RP - 1);
      end else if (ref_due) begin
        if (|open_vec) begin
          cmd_d          = CMD_PRE;
          tbl_clr_all    = 1'b1;
          addr_d[AP_BIT] = 1'b1;
          wait_d         = WAIT_W'(T_RP - 1);
        end else begin
          cmd_d     = CMD_REF;
          ref_issue = 1'b1;
          wait_d    = WAIT_W'(T_RFC - 1);
        end
      end else if (req_valid) begin
        ba_d = req_bank;
        if (!look_open) begin
          cmd_d   = CMD_ACT;
          tbl_set = 1'b1;
          addr_d  = ADDR_W'(req_row);
          wait_d  = WAIT_W'(T_RCD - 1);
        end else if (!look_hit) begin
          cmd_d   = CMD_PRE;
          tbl_clr = 1'b1;
          wait_d  = WAIT_W'(T_RP - 1);
        end else begin
          cmd_d                 = req_write ? CMD_WR : CMD_RD;
          rw_take               = 1'b1;
          addr_d[COL_W-1:0]     = req_col;
          addr_d[AP_BIT]        = req_autopre;
          wait_d = WAIT_W'(burst_hold(req_write, cfg_burst, cfg_cas) - 4'd1);
          if (req_autopre) st_d = ST_BURST;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      wait_q    <= '0;
      cmd_q     <= CMD_NOP;
      ba_q      <= '0;
      addr_q    <= '0;
      ack_q     <= 1'b0;
      ap_bank_q <= '0;
    end else begin
      st_q   <= st_d;
      wait_q <= wait_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      ack_q  <= rw_take;
      if (rw_take) ap_bank_q <= req_bank;
    end
  end

  ddr_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (tbl_set),
    .set_bank  (req_bank),
    .set_row   (req_row),
    .clr_en    (tbl_clr),
    .clr_bank  (clr_bank),
    .clr_all   (tbl_clr_all),
    .look_bank (req_bank),
    .look_row  (req_row),
    .open_vec  (open_vec),
    .look_open (look_open),
    .look_hit  (look_hit)
  );

  ddr_refresh_timer #(.T_REFI(T_REFI)) u_refresh (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_issued (ref_issue),
    .ref_due    (ref_due)
  );

  ddr_read_track u_rdtrack (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (rw_take && !req_write),
    .bl_code  (cfg_burst),
    .cl_code  (cfg_cas),
    .rd_valid (rd_valid),
    .rd_half  (rd_half)
  );

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_q;
  assign cmd_ba   = ba_q;
  assign cmd_addr = addr_q;
  assign req_ack  = ack_q;

  // R12: acknowledge only alongside a column command
  assert_ack_with_rw_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (cmd_q == CMD_RD || cmd_q == CMD_WR));

  // R3: column commands only to a bank the table holds open
  assert_rw_bank_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> open_vec[cmd_ba]);

  // R9: refresh only with every bank closed
  assert_ref_all_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |-> (open_vec == '0));

  // R5: a single-bank precharge leaves its bank closed
  assert_pre_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE && !cmd_addr[AP_BIT]) |-> !open_vec[cmd_ba]);

  if (T_RCD > 1) begin : g_rcd_gap
    // R3: row-to-column delay leaves the next cycle idle
    assert_act_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_ACT) |=> (cmd_q == CMD_NOP));
  end

endmodule

// File: tb/test_ddr_cmd_seq.sv
module test_ddr_cmd_seq;

  localparam int TRCD = 2, TRP = 2, TRFC = 5, TREFI = 300, LOGN = 1024;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  cfg_burst = 2'd1, cfg_cas = 2'd0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        req_ack, cs_n, ras_n, cas_n, we_n, rd_valid, rd_half;
  logic [1:0]  cmd_ba;
  logic [12:0] cmd_addr;

  ddr_cmd_seq #(.T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC), .T_REFI(TREFI)) i_ddr_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cfg_burst(cfg_burst), .cfg_cas(cfg_cas),
    .req_valid(req_valid), .req_write(req_write), .req_autopre(req_autopre),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_ack(req_ack),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .rd_valid(rd_valid), .rd_half(rd_half));

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, n_log = 0;
  int ref_cnt = 0, prall_cnt = 0, prall_idx = 0, ack_cnt = 0, rw_cnt = 0;
  int rv_start = 0, rv_len = 0, rv_rises = 0;
  bit rv_h = 0, rv_prev = 0, done = 0;
  logic [3:0]  log_kind [LOGN];
  logic [1:0]  log_ba   [LOGN];
  logic [12:0] log_addr [LOGN];
  int          log_cyc  [LOGN];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    logic [3:0] kind;
    kind = {cs_n, ras_n, cas_n, we_n};
    if (kind != 4'b0111 && n_log < LOGN) begin
      if (kind == 4'b0010 && cmd_addr[10]) begin prall_cnt++; prall_idx = n_log; end
      if (kind == 4'b0001) ref_cnt++;
      if (kind == 4'b0101 || kind == 4'b0100) rw_cnt++;
      log_kind[n_log] = kind; log_ba[n_log] = cmd_ba;
      log_addr[n_log] = cmd_addr; log_cyc[n_log] = cyc;
      n_log++;
    end
    if (req_ack) ack_cnt++;
    if (rd_valid && !rv_prev) begin rv_start = cyc; rv_len = 1; rv_h = rd_half; rv_rises++; end
    else if (rd_valid) rv_len++;
    rv_prev = rd_valid;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input bit w, input int bank, input int row, input int col, input bit ap);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bank = 2'(bank);
    req_row = 13'(row); req_col = 10'(col); req_autopre = ap;
    forever begin @(negedge clk); if (req_ack) break; end
    req_valid = 1'b0;
    idle(1);
  endtask

  task automatic sync_ref();
    int c;
    c = ref_cnt;
    while (ref_cnt == c) @(negedge clk);
    idle(TRFC + 2);
  endtask

  initial begin
    int base, rdc, k, p;
    repeat (3) @(negedge clk);
    chk("R1 cmd in reset", int'({cs_n, ras_n, cas_n, we_n}), 7);
    chk("R1 ack in reset", int'(req_ack), 0);
    chk("R1 rd_valid in reset", int'(rd_valid | rd_half), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cmd after reset", int'({cs_n, ras_n, cas_n, we_n}), 7);

    // R3 closed bank: ACT then RD after TRCD
    sync_ref();
    base = n_log;
    issue(0, 1, 'h123, 'h45, 0);
    idle(6);
    chk("R2 command count", n_log - base, 2);
    chk("R3 act code", int'(log_kind[base]), 3);
    chk("R3 act bank", int'(log_ba[base]), 1);
    chk("R3 act row", int'(log_addr[base]), 'h123);
    chk("R3 read code", int'(log_kind[base+1]), 5);
    chk("R3 read column", int'(log_addr[base+1]), 'h45);
    chk("R3 act to read", log_cyc[base+1] - log_cyc[base], TRCD);

    // R4 / R11 row hits survive other banks
    issue(0, 2, 'h55, 3, 0);
    issue(1, 0, 'h7, 9, 0);
    idle(4);
    base = n_log;
    issue(0, 2, 'h55, 4, 0);
    idle(4);
    chk("R11 bank2 kept: count", n_log - base, 1);
    chk("R4 read hit code", int'(log_kind[base]), 5);
    chk("R4 read hit bank", int'(log_ba[base]), 2);
    base = n_log;
    issue(1, 0, 'h7, 10, 0);
    idle(4);
    chk("R11 bank0 kept: count", n_log - base, 1);
    chk("R2 write code", int'(log_kind[base]), 4);
    chk("R4 write column", int'(log_addr[base]), 10);

    // R5 row miss
    base = n_log;
    issue(0, 2, 'h66, 1, 0);
    idle(4);
    chk("R5 count", n_log - base, 3);
    chk("R5 pre code", int'(log_kind[base]), 2);
    chk("R5 pre single", int'(log_addr[base][10]), 0);
    chk("R5 pre bank", int'(log_ba[base]), 2);
    chk("R5 pre to act", log_cyc[base+1] - log_cyc[base], TRP);
    chk("R5 act row", int'(log_addr[base+1]), 'h66);
    chk("R5 act to read", log_cyc[base+2] - log_cyc[base+1], TRCD);

    // R6 auto precharge (cl code 0, bl code 1: latency 2, 2 beats)
    issue(0, 3, 9, 2, 1);
    rdc = n_log - 1;
    chk("R6 ap flag", int'(log_addr[rdc]), 2 + 1024);
    base = n_log;
    issue(0, 3, 9, 2, 0);
    idle(4);
    chk("R6 reopen code", int'(log_kind[base]), 3);
    chk("R6 reopen gap", log_cyc[base] - log_cyc[rdc], 2 + 2 + TRP);
    chk("R6 then read", int'(log_kind[base+1]), 5);

    // R7 / R8 latency and burst sweep
    for (int c = 0; c < 3; c++) begin
      sync_ref();
      cfg_cas = 2'(c);
      for (int b = 0; b < 3; b++) begin
        cfg_burst = 2'(b);
        idle(2);
        issue(0, 0, 1, 0, 0);
        rdc = log_cyc[n_log-1];
        idle(12);
        chk($sformatf("R8 latency cl%0d bl%0d", c, b), rv_start - rdc, (c == 2) ? 3 : 2);
        chk($sformatf("R7 beats cl%0d bl%0d", c, b), rv_len, 1 << b);
        chk($sformatf("R8 half cl%0d bl%0d", c, b), int'(rv_h), (c == 1) ? 1 : 0);
      end
      k = rv_rises;
      issue(1, 0, 1, 5, 0);
      idle(12);
      chk("R7 write has no rd_valid", rv_rises, k);
    end

    // R9 / R10 refresh with open bank and a held request
    cfg_cas = 2'd0; cfg_burst = 2'd1;
    sync_ref();
    issue(0, 1, 'h20, 0, 0);
    k = prall_cnt;
    while (prall_cnt == k) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_bank = 2'd2;
    req_row = 13'h4; req_col = 10'd0; req_autopre = 1'b0;
    forever begin @(negedge clk); if (req_ack) break; end
    req_valid = 1'b0;
    idle(4);
    p = prall_idx;
    chk("R9 ref after pre-all", int'(log_kind[p+1]), 1);
    chk("R9 pre-all to ref", log_cyc[p+1] - log_cyc[p], TRP);
    chk("R10 held act code", int'(log_kind[p+2]), 3);
    chk("R10 ref to act", log_cyc[p+2] - log_cyc[p+1], TRFC);
    chk("R10 held act bank", int'(log_ba[p+2]), 2);
    chk("R10 then read", int'(log_kind[p+3]), 5);
    chk("R12 one ack per column command", ack_cnt, rw_cnt);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule